// File: doc/BRIEF.md
# Frame Buffer Burst Sequencer

This block moves whole video frames through a single-port external memory that sits between a pixel input FIFO and a compression engine. A top-level sequencer runs a fixed cycle. It stores one frame and then gives the encoder a one-cycle start pulse. When the encoder reports busy, it streams the stored frame back out. It then waits for the encoder to report done before it accepts another start of frame. Because the memory has one port, storing and streaming never overlap.

Two burst engines do the memory traffic. The memory is modelled as a command FIFO, a write-data FIFO and a read-data FIFO. All transfers use fixed bursts of `BURST_LEN` words. The write engine pops `BURST_LEN` words from the input FIFO into the write-data FIFO. Only after that does it push a write command, and it waits for the write-data FIFO to drain before it starts the next burst. The read engine pushes a read command and waits until a full burst sits in the read-data FIFO. It then forwards the words to the encoder, moving a word only in cycles where the encoder input is not full. Nothing happens on the memory side until calibration completes.

Top module: `frame_buf_seq`

## Requirements
- R1: Until `calib_done_i` has first been high, no memory command is issued (`cmd_en_o` low) and no word is popped from the input FIFO (`in_rd_o` low), even when a frame has started.
- R2: `wr_img_o` goes high the cycle after `sof_i` is sampled while the sequencer is idle, and it stays high until `eof_i` is sampled; it is low the cycle after `eof_i`.
- R3: After end of frame and once the write engine is idle, `enc_start_o` pulses for exactly one cycle per frame; no read command is issued before `enc_busy_i` has been seen high.
- R4: Once every frame word has been read, the sequencer waits for `enc_done_i`; a `sof_i` that arrives while the sequencer is reading or waiting for done is ignored, so `wr_img_o` stays low.
- R5: A write command (`cmd_rd_o` = 0) is pushed only after exactly `BURST_LEN` words have entered the write-data FIFO, and no further word is popped until `wd_empty_i` shows that the write has completed.
- R6: A read command (`cmd_rd_o` = 1) is pushed only when the previous burst has been fully forwarded, and words are taken from the read-data FIFO only after `rd_count_i` has reached `BURST_LEN`.
- R7: A word is passed to the encoder (`enc_we_o`) only in a cycle where `enc_full_i` is low.
- R8: The k-th write command and the k-th read command of a frame both carry address `BASE_ADDR + k*BURST_LEN`, and the address sequence restarts at `BASE_ADDR` for every frame.
- R9: Each frame produces exactly `FRAME_WORDS/BURST_LEN` write commands and the same number of read commands, and no more.
- R10: `cmd_en_o` is never high while `cmd_full_i` is high.
- R11: Memory reads and writes never overlap: no read command is issued while write data is pending, and no write traffic occurs while a read burst is outstanding.
- R12: The encoder receives the frame's words in the same order as they were popped from the input FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| calib_done_i | input | 1 | Memory calibration complete |
| sof_i | input | 1 | Start-of-frame pulse |
| eof_i | input | 1 | End-of-frame pulse |
| in_empty_i | input | 1 | Input FIFO empty |
| in_data_i | input | DATA_W | Input FIFO head word (first-word fall-through) |
| in_rd_o | output | 1 | Pop input FIFO |
| cmd_full_i | input | 1 | Memory command FIFO full |
| cmd_en_o | output | 1 | Push memory command |
| cmd_rd_o | output | 1 | Command type: 1 read, 0 write |
| cmd_addr_o | output | ADDR_W | Command word address |
| wd_en_o | output | 1 | Push write-data FIFO |
| wd_data_o | output | DATA_W | Write-data word |
| wd_empty_i | input | 1 | Write-data FIFO empty (write complete) |
| rd_count_i | input | $clog2(BURST_LEN+1) | Words in read-data FIFO |
| rd_data_i | input | DATA_W | Read-data FIFO head word |
| rd_en_o | output | 1 | Pop read-data FIFO |
| enc_start_o | output | 1 | Encoder start pulse |
| enc_busy_i | input | 1 | Encoder busy |
| enc_done_i | input | 1 | Encoder done pulse |
| enc_full_i | input | 1 | Encoder input buffer full |
| enc_we_o | output | 1 | Encoder input write strobe |
| enc_data_o | output | DATA_W | Word to encoder |
| wr_img_o | output | 1 | Frame store phase active |
| rd_img_o | output | 1 | Frame stream-out phase active |

## Verification
The bench holds calibration low across a started frame. A design that let the engines run early would pop input words or push commands into an uncalibrated memory. It also holds the command FIFO full for most cycles and keeps the encoder input full two cycles out of three. Under that pressure, a design that ignored either flag would push a lost command or drop a word, and the ordered data check would catch the drop. A start of frame is also pulsed while the sequencer waits for encoder done. A sequencer that accepted it would begin overwriting the frame still in use. Burst addresses are tracked per frame, so a counter that failed to rewind at the next frame would show up as an address error.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_WRITE, SQ_FLUSH, SQ_START, SQ_BUSY, SQ_READ, SQ_DONE
  } seq_st_e;

  typedef enum logic [1:0] {WE_IDLE, WE_FILL, WE_CMD, WE_WAIT} wr_st_e;

  typedef enum logic [1:0] {RE_IDLE, RE_WAIT, RE_XFER} rd_st_e;
endpackage

// File: rtl/fbs_sequencer.sv
module fbs_sequencer import fbs_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sof_i,
  input  logic eof_i,
  input  logic wr_idle_i,
  input  logic rd_done_i,
  input  logic enc_busy_i,
  input  logic enc_done_i,
  output logic frame_start_o,
  output logic wr_img_o,
  output logic rd_img_o,
  output logic enc_start_o
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE:  if (sof_i)      st_d = SQ_WRITE;
      SQ_WRITE: if (eof_i)      st_d = SQ_FLUSH;
      SQ_FLUSH: if (wr_idle_i)  st_d = SQ_START;  // last burst must land first
      SQ_START:                 st_d = SQ_BUSY;
      SQ_BUSY:  if (enc_busy_i) st_d = SQ_READ;
      SQ_READ:  if (rd_done_i)  st_d = SQ_DONE;
      SQ_DONE:  if (enc_done_i) st_d = SQ_IDLE;
      default:                  st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SQ_IDLE;
    else         st_q <= st_d;
  end

  assign frame_start_o = (st_q == SQ_IDLE) && sof_i;
  assign wr_img_o      = (st_q == SQ_WRITE);
  assign rd_img_o      = (st_q == SQ_READ);
  assign enc_start_o   = (st_q == SQ_START);

  p_start_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_start_o |=> !enc_start_o);

  p_read_after_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_img_o) |-> $past(enc_busy_i));

  p_write_on_sof_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_img_o) |-> $past(sof_i));
endmodule

// File: rtl/fbs_wr_engine.sv
module fbs_wr_engine import fbs_pkg::*; #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 20,
  parameter int BURST_LEN   = 64,
  parameter int FRAME_WORDS = 256,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              calib_i,
  input  logic              wr_img_i,
  input  logic              frame_start_i,
  input  logic              in_empty_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_rd_o,
  output logic              wd_en_o,
  output logic [DATA_W-1:0] wd_data_o,
  input  logic              wd_empty_i,
  input  logic              cmd_full_i,
  output logic              cmd_req_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              idle_o
);
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam int FCNT_W = $clog2(FRAME_WORDS + 1);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  wr_st_e            st_q, st_d;
  logic [BEAT_W-1:0] beat_q;
  logic [ADDR_W-1:0] addr_q;
  logic [FCNT_W-1:0] sent_q;
  logic              pop;

  assign pop        = (st_q == WE_FILL) && !in_empty_i;
  assign in_rd_o    = pop;
  assign wd_en_o    = pop;
  assign wd_data_o  = in_data_i;
  assign cmd_req_o  = (st_q == WE_CMD) && !cmd_full_i;
  assign cmd_addr_o = addr_q;
  assign idle_o     = (st_q == WE_IDLE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      WE_IDLE: if (calib_i && wr_img_i && sent_q < FCNT_W'(FRAME_WORDS)) st_d = WE_FILL;
      WE_FILL: if (pop && beat_q == LAST_BEAT) st_d = WE_CMD;
      WE_CMD:  if (!cmd_full_i) st_d = WE_WAIT;
      WE_WAIT: if (wd_empty_i)  st_d = WE_IDLE;
      default: st_d = WE_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= WE_IDLE;
      beat_q <= '0;
      addr_q <= BASE_ADDR;
      sent_q <= '0;
    end else begin
      st_q <= st_d;
      if (pop) beat_q <= (beat_q == LAST_BEAT) ? '0 : beat_q + 1'b1;
      if (frame_start_i) begin
        addr_q <= BASE_ADDR;
        sent_q <= '0;
      end else if (cmd_req_o) begin
        addr_q <= addr_q + ADDR_W'(BURST_LEN);
        sent_q <= sent_q + FCNT_W'(BURST_LEN);
      end
    end
  end

  p_no_pop_after_cmd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_req_o |=> !in_rd_o);

  p_frame_limit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sent_q <= FCNT_W'(FRAME_WORDS));
endmodule

// File: rtl/fbs_rd_engine.sv
module fbs_rd_engine import fbs_pkg::*; #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 20,
  parameter int BURST_LEN   = 64,
  parameter int FRAME_WORDS = 256,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  localparam int CNT_W = $clog2(BURST_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              calib_i,
  input  logic              rd_img_i,
  input  logic              frame_start_i,
  input  logic              cmd_full_i,
  output logic              cmd_req_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  input  logic [CNT_W-1:0]  rd_count_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rd_en_o,
  input  logic              enc_full_i,
  output logic              enc_we_o,
  output logic [DATA_W-1:0] enc_data_o,
  output logic              idle_o,
  output logic              done_o
);
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam int FCNT_W = $clog2(FRAME_WORDS + 1);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  rd_st_e            st_q, st_d;
  logic [BEAT_W-1:0] beat_q;
  logic [ADDR_W-1:0] addr_q;
  logic [FCNT_W-1:0] req_q;
  logic              mv;

  assign cmd_req_o  = (st_q == RE_IDLE) && calib_i && rd_img_i &&
                      (req_q < FCNT_W'(FRAME_WORDS)) && !cmd_full_i;
  assign cmd_addr_o = addr_q;
  assign mv         = (st_q == RE_XFER) && !enc_full_i;
  assign rd_en_o    = mv;
  assign enc_we_o   = mv;
  assign enc_data_o = rd_data_i;
  assign idle_o     = (st_q == RE_IDLE);
  assign done_o     = (st_q == RE_IDLE) && (req_q == FCNT_W'(FRAME_WORDS));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      RE_IDLE: if (cmd_req_o) st_d = RE_WAIT;
      RE_WAIT: if (rd_count_i >= CNT_W'(BURST_LEN)) st_d = RE_XFER;
      RE_XFER: if (mv && beat_q == LAST_BEAT) st_d = RE_IDLE;
      default: st_d = RE_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RE_IDLE;
      beat_q <= '0;
      addr_q <= BASE_ADDR;
      req_q  <= '0;
    end else begin
      st_q <= st_d;
      if (mv) beat_q <= (beat_q == LAST_BEAT) ? '0 : beat_q + 1'b1;
      if (frame_start_i) begin
        addr_q <= BASE_ADDR;
        req_q  <= '0;
      end else if (cmd_req_o) begin
        addr_q <= addr_q + ADDR_W'(BURST_LEN);
        req_q  <= req_q + FCNT_W'(BURST_LEN);
      end
    end
  end

  p_pop_has_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> (rd_count_i != '0));

  p_cmd_on_drained_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_req_o |-> (rd_count_i == '0));
endmodule

// File: rtl/frame_buf_seq.sv
module frame_buf_seq import fbs_pkg::*; #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 20,
  parameter int BURST_LEN   = 64,
  parameter int FRAME_WORDS = 256,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  localparam int CNT_W = $clog2(BURST_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              calib_done_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              in_empty_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_rd_o,
  input  logic              cmd_full_i,
  output logic              cmd_en_o,
  output logic              cmd_rd_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              wd_en_o,
  output logic [DATA_W-1:0] wd_data_o,
  input  logic              wd_empty_i,
  input  logic [CNT_W-1:0]  rd_count_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rd_en_o,
  output logic              enc_start_o,
  input  logic              enc_busy_i,
  input  logic              enc_done_i,
  input  logic              enc_full_i,
  output logic              enc_we_o,
  output logic [DATA_W-1:0] enc_data_o,
  output logic              wr_img_o,
  output logic              rd_img_o
);
  logic              frame_start;
  logic              w_idle, r_idle, r_done;
  logic              w_cmd, r_cmd;
  logic [ADDR_W-1:0] w_addr, r_addr;

  fbs_sequencer u_seq (
    .clk_i, .rst_ni, .sof_i, .eof_i,
    .wr_idle_i(w_idle), .rd_done_i(r_done),
    .enc_busy_i, .enc_done_i,
    .frame_start_o(frame_start), .wr_img_o, .rd_img_o, .enc_start_o
  );

  fbs_wr_engine #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN),
    .FRAME_WORDS(FRAME_WORDS), .BASE_ADDR(BASE_ADDR)
  ) u_wr (
    .clk_i, .rst_ni, .calib_i(calib_done_i), .wr_img_i(wr_img_o),
    .frame_start_i(frame_start), .in_empty_i, .in_data_i, .in_rd_o,
    .wd_en_o, .wd_data_o, .wd_empty_i, .cmd_full_i,
    .cmd_req_o(w_cmd), .cmd_addr_o(w_addr), .idle_o(w_idle)
  );

  fbs_rd_engine #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN),
    .FRAME_WORDS(FRAME_WORDS), .BASE_ADDR(BASE_ADDR)
  ) u_rd (
    .clk_i, .rst_ni, .calib_i(calib_done_i), .rd_img_i(rd_img_o),
    .frame_start_i(frame_start), .cmd_full_i,
    .cmd_req_o(r_cmd), .cmd_addr_o(r_addr),
    .rd_count_i, .rd_data_i, .rd_en_o, .enc_full_i, .enc_we_o, .enc_data_o,
    .idle_o(r_idle), .done_o(r_done)
  );

  // engines are serialised by the sequencer, so at most one requests
  assign cmd_en_o   = w_cmd | r_cmd;
  assign cmd_rd_o   = r_cmd;
  assign cmd_addr_o = r_cmd ? r_addr : w_addr;

  logic calib_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           calib_seen_q <= 1'b0;
    else if (calib_done_i) calib_seen_q <= 1'b1;
  end

  p_calib_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!calib_seen_q && !calib_done_i) |-> (!cmd_en_o && !in_rd_o));

  p_no_cmd_when_full_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_en_o |-> !cmd_full_i);

  p_no_overlap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!w_idle && !r_idle));

  p_fwd_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_we_o |-> !enc_full_i);
endmodule

// File: tb/tb_frame_buf_seq.sv
module tb_frame_buf_seq;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 256;
  localparam int BURST      = 64;
  localparam int NBURST     = FRAME / BURST;

  // event counter indices
  localparam int EV_WCMD = 0, EV_RCMD = 1, EV_ADDR = 2, EV_FILL = 3, EV_RDCMD = 4,
                 EV_CFULL = 5, EV_FWD = 6, EV_DATA = 7, EV_START = 8, EV_EARLY = 9,
                 EV_OVL = 10, EV_NOCAL = 11, EV_POP = 12, EV_N = 13;

  // row: {in_mod, full_mod, cmdf_mod, done_dly, exp_bursts}
  localparam logic [39:0] VEC [5] = '{
    {8'd0, 8'd0, 8'd0, 8'd4,  8'd4},
    {8'd3, 8'd0, 8'd0, 8'd4,  8'd4},
    {8'd0, 8'd3, 8'd0, 8'd4,  8'd4},
    {8'd0, 8'd0, 8'd5, 8'd4,  8'd4},
    {8'd4, 8'd2, 8'd3, 8'd10, 8'd4}
  };

  logic        clk = 1'b0, rst_n = 1'b0, calib = 1'b0, sof = 1'b0, eof = 1'b0;
  logic        in_empty, in_rd, cmd_full, cmd_en, cmd_rd, wd_en, wd_empty, rd_en;
  logic        enc_start, enc_full, enc_we, wr_img, rd_img;
  logic        enc_busy = 1'b0, enc_done = 1'b0;
  logic [15:0] in_data, wd_data, rd_data, enc_data;
  logic [19:0] cmd_addr;
  logic [6:0]  rd_count;

  int cyc = 0, checks = 0, errors = 0;
  int seed = 0, in_mod = 0, full_mod = 0, cmdf_mod = 0, done_dly = 4;
  int src_n = 0, wk = 0, rk = 0, rcv = 0, dtmr = 0;
  int wcount = 0, wt = 0, rcount = 0, rptr = 0, rt = 0;
  logic wdrain = 1'b0, rpend = 1'b0;
  int raddr = 0;
  logic [15:0] mem [FRAME];
  logic [15:0] wbuf [BURST];
  int ev [EV_N] = '{default: 0};
  int base [EV_N];

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_buf_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .calib_done_i(calib), .sof_i(sof), .eof_i(eof),
    .in_empty_i(in_empty), .in_data_i(in_data), .in_rd_o(in_rd),
    .cmd_full_i(cmd_full), .cmd_en_o(cmd_en), .cmd_rd_o(cmd_rd), .cmd_addr_o(cmd_addr),
    .wd_en_o(wd_en), .wd_data_o(wd_data), .wd_empty_i(wd_empty),
    .rd_count_i(rd_count), .rd_data_i(rd_data), .rd_en_o(rd_en),
    .enc_start_o(enc_start), .enc_busy_i(enc_busy), .enc_done_i(enc_done),
    .enc_full_i(enc_full), .enc_we_o(enc_we), .enc_data_o(enc_data),
    .wr_img_o(wr_img), .rd_img_o(rd_img)
  );

  assign in_empty = (src_n >= FRAME) || (in_mod != 0 && cyc % in_mod == 0);
  assign in_data  = 16'(seed * 1000 + src_n);
  assign cmd_full = (cmdf_mod != 0) && (cyc % cmdf_mod != 0);
  assign enc_full = (full_mod != 0) && (cyc % full_mod != 0);
  assign wd_empty = (wcount == 0);
  assign rd_count = 7'(rcount);
  assign rd_data  = mem[rptr % FRAME];

  // memory, input FIFO and encoder models plus protocol monitors
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (sof) begin src_n <= 0; wk <= 0; rk <= 0; end
    if (in_rd) begin
      src_n <= src_n + 1;
      ev[EV_POP] <= ev[EV_POP] + 1;
      if (in_empty) ev[EV_FILL] <= ev[EV_FILL] + 1;
    end
    if ((in_rd || cmd_en) && !calib) ev[EV_NOCAL] <= ev[EV_NOCAL] + 1;
    if (cmd_en && cmd_full) ev[EV_CFULL] <= ev[EV_CFULL] + 1;
    if (wd_en) begin
      wbuf[wcount % BURST] <= wd_data;
      wcount <= wcount + 1;
      if (rpend || rcount != 0) ev[EV_OVL] <= ev[EV_OVL] + 1;
    end
    if (cmd_en && !cmd_rd) begin
      ev[EV_WCMD] <= ev[EV_WCMD] + 1;
      wk <= wk + 1;
      if (int'(cmd_addr) != wk * BURST) ev[EV_ADDR] <= ev[EV_ADDR] + 1;
      if (wcount != BURST || wdrain) ev[EV_FILL] <= ev[EV_FILL] + 1;
      if (rpend || rcount != 0) ev[EV_OVL] <= ev[EV_OVL] + 1;
      for (int i = 0; i < BURST; i++) mem[(int'(cmd_addr) + i) % FRAME] <= wbuf[i];
      wdrain <= 1'b1;
      wt <= 0;
    end
    if (wdrain) begin
      if (wt == 3) begin wcount <= 0; wdrain <= 1'b0; end
      else wt <= wt + 1;
    end
    if (cmd_en && cmd_rd) begin
      ev[EV_RCMD] <= ev[EV_RCMD] + 1;
      rk <= rk + 1;
      if (int'(cmd_addr) != rk * BURST) ev[EV_ADDR] <= ev[EV_ADDR] + 1;
      if (rcount != 0 || rpend) ev[EV_RDCMD] <= ev[EV_RDCMD] + 1;
      if (!enc_busy) ev[EV_EARLY] <= ev[EV_EARLY] + 1;
      if (wcount != 0 || wr_img) ev[EV_OVL] <= ev[EV_OVL] + 1;
      rpend <= 1'b1;
      rt <= 0;
      raddr <= int'(cmd_addr);
    end
    if (rpend) begin
      if (rt == 4) begin rcount <= BURST; rptr <= raddr; rpend <= 1'b0; end
      else rt <= rt + 1;
    end
    if (rd_en) begin
      if (rcount == 0) ev[EV_RDCMD] <= ev[EV_RDCMD] + 1;
      rcount <= rcount - 1;
      rptr <= rptr + 1;
    end
    enc_done <= 1'b0;
    if (enc_start) begin
      enc_busy <= 1'b1;
      rcv <= 0;
      dtmr <= 0;
      ev[EV_START] <= ev[EV_START] + 1;
    end else if (enc_busy && rcv == FRAME) begin
      if (dtmr == done_dly) begin enc_done <= 1'b1; enc_busy <= 1'b0; end
      else dtmr <= dtmr + 1;
    end
    if (enc_we) begin
      if (enc_full) ev[EV_FWD] <= ev[EV_FWD] + 1;
      if (enc_data != 16'(seed * 1000 + rcv)) ev[EV_DATA] <= ev[EV_DATA] + 1;
      rcv <= rcv + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int dl(input int idx);
    return ev[idx] - base[idx];
  endfunction

  task automatic run_frame(input int s, input int im, input int fm, input int cm,
                           input int dd, input int exp_b, input int cal_hold, input bit late_sof);
    seed = s; in_mod = im; full_mod = fm; cmdf_mod = cm; done_dly = dd;
    for (int i = 0; i < EV_N; i++) base[i] = ev[i];
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
    chk(wr_img == 1'b1, "R2", "wr_img after sof", int'(wr_img), 1);
    if (cal_hold > 0) begin
      repeat (cal_hold) @(negedge clk);
      chk(dl(EV_POP) == 0, "R1", "pops before calibration", dl(EV_POP), 0);
      chk(dl(EV_WCMD) + dl(EV_RCMD) == 0, "R1", "cmds before calibration",
          dl(EV_WCMD) + dl(EV_RCMD), 0);
      chk(dl(EV_NOCAL) == 0, "R1", "activity without calibration", dl(EV_NOCAL), 0);
      calib = 1'b1;
    end
    while (src_n != FRAME) @(negedge clk);
    repeat (2) @(negedge clk);
    eof = 1'b1;
    @(negedge clk); eof = 1'b0;
    chk(wr_img == 1'b0, "R2", "wr_img after eof", int'(wr_img), 0);
    if (late_sof) begin
      while (dl(EV_START) == 0) @(negedge clk);
      while (rcv != FRAME) @(negedge clk);
      @(negedge clk); sof = 1'b1;
      @(negedge clk); sof = 1'b0;
      chk(wr_img == 1'b0, "R4", "sof during done wait ignored", int'(wr_img), 0);
    end
    while (!enc_done) @(negedge clk);
    repeat (2) @(negedge clk);
    if (late_sof)
      chk(wr_img == 1'b0, "R4", "no frame started after done", int'(wr_img), 0);
    chk(dl(EV_WCMD) == exp_b, "R9", "write commands per frame", dl(EV_WCMD), exp_b);
    chk(dl(EV_RCMD) == exp_b, "R9", "read commands per frame", dl(EV_RCMD), exp_b);
    chk(dl(EV_ADDR) == 0, "R8", "burst address errors", dl(EV_ADDR), 0);
    chk(dl(EV_FILL) == 0, "R5", "write cmd before full burst", dl(EV_FILL), 0);
    chk(dl(EV_RDCMD) == 0, "R6", "read burst ordering errors", dl(EV_RDCMD), 0);
    chk(dl(EV_CFULL) == 0, "R10", "cmd while cmd fifo full", dl(EV_CFULL), 0);
    chk(dl(EV_FWD) == 0, "R7", "forward while encoder full", dl(EV_FWD), 0);
    chk(dl(EV_START) == 1, "R3", "encoder start pulses", dl(EV_START), 1);
    chk(dl(EV_EARLY) == 0, "R3", "read cmd before busy", dl(EV_EARLY), 0);
    chk(dl(EV_OVL) == 0, "R11", "read/write overlap", dl(EV_OVL), 0);
    chk(dl(EV_DATA) == 0 && rcv == FRAME, "R12", "words delivered in order",
        rcv - dl(EV_DATA), FRAME);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog: actual=timeout expected=frame complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_en == 1'b0, "R1", "reset cmd_en", int'(cmd_en), 0);
    chk(in_rd == 1'b0, "R1", "reset in_rd", int'(in_rd), 0);
    chk(enc_start == 1'b0, "R3", "reset enc_start", int'(enc_start), 0);
    chk(wr_img == 1'b0, "R2", "reset wr_img", int'(wr_img), 0);
    chk(rd_img == 1'b0, "R4", "reset rd_img", int'(rd_img), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // calibration held low across the start of a frame
    run_frame(1, 0, 0, 0, 4, NBURST, 40, 1'b0);

    for (int r = 0; r < 5; r++) begin
      run_frame(r + 2, int'(VEC[r][39:32]), int'(VEC[r][31:24]), int'(VEC[r][23:16]),
                int'(VEC[r][15:8]), int'(VEC[r][7:0]), 0, 1'b0);
    end

    // start of frame pulsed while waiting for encoder done
    run_frame(9, 2, 3, 0, 30, NBURST, 0, 1'b1);

    // next frame after the ignored one still starts from the base address
    run_frame(10, 0, 0, 2, 4, NBURST, 0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule